// File: doc/BRIEF.md
# Extended RAM bank shadow selector

This block lives next to an existing 8-bit memory manager and tracks the RAM-bank bits the manager cannot hold. The result is that four 64 KB banks (256 KB in total) can be used. It watches CPU writes to the configuration register, the four preset registers, the load strobes, the RAM setup register and the two page-pointer high bytes. It keeps its own copy of every bank field. Writing a preset register only stores a value. Writing a load strobe makes that preset the live configuration.

For each memory cycle the block chooses one 2-bit bank from three sources:
- the live CPU configuration;
- the video bank, when the video chip owns the bus;
- a relocated page pointer, for CPU accesses to page $00 or page $01.

It then forces bank 0 inside the shared (common) area, if one is set up. The chosen bank is sent to the three select inputs of a 3-to-8 decoder, qualified by a single combined RAM-request input. Software can read back every field the block holds.

Top module: `bank_shadow`

## Requirements
- R1: A CPU write to I/O offset 0, or to address $FF00 with `io_sel` low, stores data bits 7:6 as the CPU bank. From the next cycle that bank is used for CPU accesses outside page $00, page $01 and the common area.
- R2: A write to I/O offsets 1 to 4 stores data bits 7:6 in preset 0 to 3. The active CPU bank does not change.
- R3: A write to $FF01 to $FF04 (with `io_sel` low) copies preset 0 to 3 into the CPU bank. The data written is ignored.
- R4: A write to I/O offset 6 stores bits 7:6 as the video bank and bits 3:0 as the common setup. Whenever `phi0` or `aec` is low, the video chip owns the bus and the bank output is the video bank, whatever the address.
- R5: The common setup works as follows. Bits 1:0 select the size: 00 = 1 KB, 01 = 4 KB, 10 = 8 KB, 11 = 16 KB. Bit 2 enables a bottom area (address < size). Bit 3 enables a top area (address >= 65536 - size). A CPU access inside an enabled area uses bank 0.
- R6: A write to I/O offset 8 stores data bits 1:0 as the zero-page bank, and offset 10 stores the stack bank the same way. CPU accesses to page $00 and page $01 use these banks, ahead of both the common area and the CPU bank.
- R7: `dec_sel` is {1, bank} while `ram_req` is high and 000 while it is low.
- R8: Reset clears every stored field to 0.
- R9: Reads from the I/O page return the stored fields:
  - offsets 0 to 4: the bank at bits 7:6;
  - offset 6: {video bank, 00, common setup};
  - offsets 8 and 10: the bank at bits 1:0;
  - all other offsets: 0.
  With `io_sel` low, $FF00 reads the CPU bank at bits 7:6 and every other address reads 0.
- R10: A write has no effect on any field in these cases: `cpu_we` is low, the video chip owns the bus, the I/O offset is not 0 to 4, 6, 8 or 10, or the address is outside $FF00 to $FF04 while `io_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Current bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write in this cycle |
| io_sel | input | 1 | Address lies in the manager's I/O page (offset = cpu_addr[4:0]) |
| phi0 | input | 1 | Bus phase; low means video phase |
| aec | input | 1 | Bus grant; low means video chip owns bus |
| ram_req | input | 1 | Combined RAM access request |
| dec_sel | output | 3 | Decoder select: {request, bank} |
| rd_data | output | 8 | Readback of stored fields |

## Verification
The hardest case to reach is a page $00 or $01 access while a bottom common area is enabled and the zero-page or stack bank differs from both bank 0 and the CPU bank. Three separately written registers have to line up before the R6 precedence over R5 shows at all.

The bench reaches this case with directed writes first. Random runs then keep rewriting the pointers, presets and setup register, and aim probe addresses at page $00 and $01 and at every common-area edge. A second hidden case is a load strobe that copies a preset written many cycles earlier. Random strobe writes that carry random data cover it.

// File: rtl/bank_shadow_pkg.sv
package bank_shadow_pkg;
  localparam int ADDR_W     = 16;
  localparam int OFS_CFG    = 0;
  localparam int OFS_PRE0   = 1;
  localparam int OFS_RAMCFG = 6;
  localparam int OFS_ZPH    = 8;
  localparam int OFS_SPH    = 10;

  // size of the common area in bytes for a 2-bit size code
  function automatic logic [16:0] common_size(input logic [1:0] code);
    logic [4:0] sh;
    sh = (code == 2'd0) ? 5'd10 : 5'd11 + {3'd0, code};
    return 17'd1 << sh;
  endfunction

  // address lies in an enabled bottom or top shared area
  function automatic logic common_hit(input logic [ADDR_W-1:0] a, input logic [3:0] setup);
    logic [16:0] sz;
    sz = common_size(setup[1:0]);
    return (setup[2] && ({1'b0, a} < sz)) ||
           (setup[3] && ({1'b0, a} >= (17'h10000 - sz)));
  endfunction
endpackage

// File: rtl/bank_shadow_regs.sv
module bank_shadow_regs
  import bank_shadow_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int N_PRE  = 4,
  localparam int LDW   = $clog2(N_PRE)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           io_hit,
  input  logic                           ff_hit,
  input  logic [4:0]                     ofs,
  input  logic [7:0]                     ff_ofs,
  input  logic [7:0]                     wdata,
  output logic [BANK_W-1:0]              cfg_q,
  output logic [N_PRE-1:0][BANK_W-1:0]   pre_q,
  output logic [BANK_W-1:0]              vid_q,
  output logic [3:0]                     com_q,
  output logic [BANK_W-1:0]              zp_q,
  output logic [BANK_W-1:0]              sp_q,
  output logic                           pre_wr,
  output logic                           ld_wr,
  output logic [LDW-1:0]                 ld_idx,
  output logic [7:0]                     rd_data
);
  logic             cfg_wr;
  logic [N_PRE-1:0] pre_we;

  assign cfg_wr = wr_en && ((io_hit && ofs == 5'(OFS_CFG)) || (ff_hit && ff_ofs == 8'd0));
  assign ld_wr  = wr_en && ff_hit && (ff_ofs != 8'd0);
  assign ld_idx = LDW'(ff_ofs - 8'd1);

  for (genvar i = 0; i < N_PRE; i++) begin : g_pre_we
    assign pre_we[i] = wr_en && io_hit && (ofs == 5'(OFS_PRE0 + i));
  end
  assign pre_wr = |pre_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      pre_q <= '0;
      vid_q <= '0;
      com_q <= '0;
      zp_q  <= '0;
      sp_q  <= '0;
    end else begin
      if (cfg_wr)     cfg_q <= wdata[7 -: BANK_W];
      else if (ld_wr) cfg_q <= pre_q[ld_idx];
      for (int i = 0; i < N_PRE; i++)
        if (pre_we[i]) pre_q[i] <= wdata[7 -: BANK_W];
      if (wr_en && io_hit && ofs == 5'(OFS_RAMCFG)) begin
        vid_q <= wdata[7 -: BANK_W];
        com_q <= wdata[3:0];
      end
      if (wr_en && io_hit && ofs == 5'(OFS_ZPH)) zp_q <= wdata[BANK_W-1:0];
      if (wr_en && io_hit && ofs == 5'(OFS_SPH)) sp_q <= wdata[BANK_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (io_hit) begin
      if (ofs == 5'(OFS_CFG))
        rd_data[7 -: BANK_W] = cfg_q;
      else if (ofs >= 5'(OFS_PRE0) && ofs < 5'(OFS_PRE0 + N_PRE))
        rd_data[7 -: BANK_W] = pre_q[LDW'(ofs - 5'(OFS_PRE0))];
      else if (ofs == 5'(OFS_RAMCFG)) begin
        rd_data[7 -: BANK_W] = vid_q;
        rd_data[3:0]         = com_q;
      end else if (ofs == 5'(OFS_ZPH))
        rd_data[BANK_W-1:0] = zp_q;
      else if (ofs == 5'(OFS_SPH))
        rd_data[BANK_W-1:0] = sp_q;
    end else if (ff_hit && ff_ofs == 8'd0) begin
      rd_data[7 -: BANK_W] = cfg_q;
    end
  end
endmodule

// File: rtl/bank_shadow_pick.sv
module bank_shadow_pick
  import bank_shadow_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              cpu_own,
  input  logic              ram_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] cfg,
  input  logic [BANK_W-1:0] vid,
  input  logic [BANK_W-1:0] zp,
  input  logic [BANK_W-1:0] sp,
  input  logic [3:0]        com,
  output logic              zp_use,
  output logic              sp_use,
  output logic              com_use,
  output logic [BANK_W:0]   dec_sel
);
  logic [BANK_W-1:0] bank;

  assign zp_use  = cpu_own && addr[15:8] == 8'h00;
  assign sp_use  = cpu_own && addr[15:8] == 8'h01;
  assign com_use = cpu_own && !zp_use && !sp_use && common_hit(addr, com);

  always_comb begin
    if (!cpu_own)     bank = vid;
    else if (zp_use)  bank = zp;
    else if (sp_use)  bank = sp;
    else if (com_use) bank = '0;
    else              bank = cfg;
    dec_sel = ram_req ? {1'b1, bank} : '0;
  end
endmodule

// File: rtl/bank_shadow.sv
module bank_shadow
  import bank_shadow_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int N_PRE  = 4,
  localparam int LDW   = $clog2(N_PRE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  input  logic              io_sel,
  input  logic              phi0,
  input  logic              aec,
  input  logic              ram_req,
  output logic [BANK_W:0]   dec_sel,
  output logic [7:0]        rd_data
);
  logic                         cpu_own, wr_en, ff_hit;
  logic [BANK_W-1:0]            cfg_q, vid_q, zp_q, sp_q;
  logic [N_PRE-1:0][BANK_W-1:0] pre_q;
  logic [3:0]                   com_q;
  logic                         pre_wr, ld_wr;
  logic [LDW-1:0]               ld_idx;
  logic                         zp_use, sp_use, com_use;

  assign cpu_own = phi0 && aec;
  assign wr_en   = cpu_we && cpu_own;
  assign ff_hit  = !io_sel && cpu_addr[15:8] == 8'hFF && cpu_addr[7:0] <= 8'(N_PRE);

  bank_shadow_regs #(.BANK_W(BANK_W), .N_PRE(N_PRE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .io_hit(io_sel), .ff_hit(ff_hit),
    .ofs(cpu_addr[4:0]), .ff_ofs(cpu_addr[7:0]), .wdata(cpu_wdata),
    .cfg_q(cfg_q), .pre_q(pre_q), .vid_q(vid_q), .com_q(com_q), .zp_q(zp_q), .sp_q(sp_q),
    .pre_wr(pre_wr), .ld_wr(ld_wr), .ld_idx(ld_idx), .rd_data(rd_data)
  );

  bank_shadow_pick #(.BANK_W(BANK_W)) u_pick (
    .cpu_own(cpu_own), .ram_req(ram_req), .addr(cpu_addr),
    .cfg(cfg_q), .vid(vid_q), .zp(zp_q), .sp(sp_q), .com(com_q),
    .zp_use(zp_use), .sp_use(sp_use), .com_use(com_use), .dec_sel(dec_sel)
  );
endmodule

// File: rtl/bank_shadow_chk.sv
module bank_shadow_chk #(
  parameter int BANK_W = 2,
  parameter int N_PRE  = 4,
  localparam int LDW   = $clog2(N_PRE)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [15:0]                  cpu_addr,
  input logic                         cpu_own,
  input logic                         ram_req,
  input logic                         pre_wr,
  input logic                         ld_wr,
  input logic [LDW-1:0]               ld_idx,
  input logic [BANK_W-1:0]            cfg_q,
  input logic [N_PRE-1:0][BANK_W-1:0] pre_q,
  input logic [BANK_W-1:0]            vid_q,
  input logic [BANK_W-1:0]            zp_q,
  input logic [BANK_W:0]              dec_sel
);
  p_preset_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wr |=> $stable(cfg_q));

  p_load_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr |=> cfg_q == $past(pre_q[ld_idx]));

  p_video_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && !cpu_own) |-> dec_sel == {1'b1, vid_q});

  p_zero_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && cpu_own && cpu_addr[15:8] == 8'h00) |-> dec_sel[BANK_W-1:0] == zp_q);

  p_idle_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_req |-> dec_sel == '0);

  p_reset_clear_r8: assert property (@(posedge clk)
    !rst_n |=> (cfg_q == '0 && vid_q == '0 && zp_q == '0 && pre_q == '0));
endmodule

bind bank_shadow bank_shadow_chk #(.BANK_W(BANK_W), .N_PRE(N_PRE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_own(cpu_own), .ram_req(ram_req),
  .pre_wr(pre_wr), .ld_wr(ld_wr), .ld_idx(ld_idx), .cfg_q(cfg_q), .pre_q(pre_q),
  .vid_q(vid_q), .zp_q(zp_q), .dec_sel(dec_sel)
);

// File: tb/bank_shadow_bench.sv
module bank_shadow_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0, io_sel = 1'b0, phi0 = 1'b1, aec = 1'b1, ram_req = 1'b0;
  logic [2:0]  dec_sel;
  logic [7:0]  rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [1:0] m_cfg, m_vid, m_zp, m_sp;
  logic [1:0] m_pre [4];
  logic [3:0] m_com;

  bank_shadow u_bank_shadow (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .io_sel(io_sel), .phi0(phi0), .aec(aec), .ram_req(ram_req), .dec_sel(dec_sel), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cfg = 0; m_vid = 0; m_zp = 0; m_sp = 0; m_com = 0;
    for (int i = 0; i < 4; i++) m_pre[i] = 0;
  endtask

  task automatic model_write(input bit io, input logic [15:0] a, input logic [7:0] d);
    if (io) begin
      case (a[4:0])
        5'd0: m_cfg = d[7:6];
        5'd1, 5'd2, 5'd3, 5'd4: m_pre[a[4:0]-1] = d[7:6];
        5'd6: begin m_vid = d[7:6]; m_com = d[3:0]; end
        5'd8: m_zp = d[1:0];
        5'd10: m_sp = d[1:0];
        default: ;
      endcase
    end else if (a == 16'hFF00) m_cfg = d[7:6];
    else if (a >= 16'hFF01 && a <= 16'hFF04) m_cfg = m_pre[a - 16'hFF01];
  endtask

  function automatic int exp_dec(input logic [15:0] a, input bit own, input bit req);
    int sz;
    if (!req) return 0;
    if (!own) return 4 + m_vid;
    if (a < 16'h0100) return 4 + m_zp;
    if (a < 16'h0200) return 4 + m_sp;
    case (m_com[1:0])
      2'b00: sz = 1024;
      2'b01: sz = 4096;
      2'b10: sz = 8192;
      default: sz = 16384;
    endcase
    if (m_com[2] && int'(a) <= sz - 1) return 4;
    if (m_com[3] && int'(a) > 65535 - sz) return 4;
    return 4 + m_cfg;
  endfunction

  function automatic string dec_req(input logic [15:0] a, input bit own, input bit req);
    if (!req) return "R7";
    if (!own) return "R4";
    if (a < 16'h0200) return "R6";
    if (exp_dec(a, own, req) == 4 && m_cfg != 0) return "R5";
    return "R1";
  endfunction

  function automatic int exp_rd(input bit io, input logic [15:0] a);
    if (io) begin
      case (a[4:0])
        5'd0: return {m_cfg, 6'd0};
        5'd1, 5'd2, 5'd3, 5'd4: return {m_pre[a[4:0]-1], 6'd0};
        5'd6: return {m_vid, 2'b00, m_com};
        5'd8: return {6'd0, m_zp};
        5'd10: return {6'd0, m_sp};
        default: return 0;
      endcase
    end
    return (a == 16'hFF00) ? {m_cfg, 6'd0} : 0;
  endfunction

  task automatic wr(input bit io, input logic [15:0] a, input logic [7:0] d, input bit own = 1, input bit we = 1);
    @(negedge clk);
    io_sel = io; cpu_addr = a; cpu_wdata = d; cpu_we = we; phi0 = 1'b1; aec = own; ram_req = 1'b0;
    @(posedge clk);
    if (own && we) model_write(io, a, d);
    @(negedge clk);
    cpu_we = 1'b0; aec = 1'b1; io_sel = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input bit p0, input bit ae, input bit req, input string tag = "");
    @(negedge clk);
    io_sel = 1'b0; cpu_we = 1'b0; cpu_addr = a; phi0 = p0; aec = ae; ram_req = req;
    #1;
    check(tag == "" ? dec_req(a, p0 && ae, req) : tag, $sformatf("dec_sel @%h", a),
          int'(dec_sel), exp_dec(a, p0 && ae, req));
  endtask

  task automatic readback(input bit io, input logic [15:0] a, input string tag = "R9");
    @(negedge clk);
    io_sel = io; cpu_we = 1'b0; cpu_addr = a; phi0 = 1'b1; aec = 1'b1; ram_req = 1'b0;
    #1;
    check(tag, $sformatf("rd_data io=%0d @%h", io, a), int'(rd_data), exp_rd(io, a));
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] edges [19] = '{16'h0000, 16'h00FF, 16'h0100, 16'h01FF, 16'h0200, 16'h03FF,
      16'h0400, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'hBFFF,
      16'hC000, 16'hDFFF, 16'hE000, 16'hEFFF, 16'hFC00};
    if ($urandom_range(0, 3) == 0) return 16'($urandom);
    return edges[$urandom_range(0, 18)];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL all watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    model_reset();
    repeat (3) @(negedge clk);
    // R8 reset state
    ram_req = 1'b1; cpu_addr = 16'h8000; #1;
    check("R8", "dec_sel in reset", int'(dec_sel), 4);
    io_sel = 1'b1; cpu_addr = 16'hD500; #1;
    check("R8", "rd cfg in reset", int'(rd_data), 0);
    @(negedge clk); rst_n = 1'b1; io_sel = 1'b0;
    readback(1, 16'hD506, "R8");

    // R1 via I/O page and $FF00
    wr(1, 16'hD500, 8'hC0);
    probe(16'h8000, 1, 1, 1, "R1");
    wr(0, 16'hFF00, 8'h40);
    probe(16'h8000, 1, 1, 1, "R1");

    // R2 presets do not change mapping
    wr(1, 16'hD501, 8'h00); wr(1, 16'hD502, 8'h40);
    wr(1, 16'hD503, 8'h80); wr(1, 16'hD504, 8'hC0);
    probe(16'h8000, 1, 1, 1, "R2");
    readback(1, 16'hD503, "R2");

    // R3 load strobes ignore data
    wr(0, 16'hFF03, 8'h00);
    probe(16'h8000, 1, 1, 1, "R3");
    wr(0, 16'hFF04, 8'h3F);
    probe(16'h8000, 1, 1, 1, "R3");

    // R4 video ownership
    wr(1, 16'hD506, 8'h80);
    probe(16'h8000, 1, 0, 1, "R4");
    probe(16'h0010, 0, 1, 1, "R4");

    // R5 common areas
    wr(1, 16'hD506, 8'h84);
    probe(16'h03FF, 1, 1, 1, "R5");
    probe(16'h0400, 1, 1, 1, "R5");
    wr(1, 16'hD506, 8'h0B);
    probe(16'hC000, 1, 1, 1, "R5");
    probe(16'hBFFF, 1, 1, 1, "R5");

    // R6 page pointers beat common area
    wr(1, 16'hD506, 8'h07);
    wr(1, 16'hD508, 8'hFD); wr(1, 16'hD50A, 8'h02);
    probe(16'h0010, 1, 1, 1, "R6");
    probe(16'h01FF, 1, 1, 1, "R6");
    probe(16'h0200, 1, 1, 1, "R5");

    // R7 idle
    probe(16'h8000, 1, 1, 0, "R7");

    // R10 ignored writes
    wr(1, 16'hD500, 8'h00, 0);
    probe(16'h8000, 1, 1, 1, "R10");
    wr(1, 16'hD505, 8'hFF);
    readback(1, 16'hD505, "R10");
    wr(1, 16'hD507, 8'hFF);
    readback(1, 16'hD508, "R10");
    wr(0, 16'hFF05, 8'h00);
    probe(16'h8000, 1, 1, 1, "R10");
    wr(1, 16'hD500, 8'h00, 1, 0);
    readback(1, 16'hD500, "R10");
    wr(0, 16'h1234, 8'h00);
    readback(0, 16'hFF00, "R10");

    // R9 readback across the map
    for (int o = 0; o < 12; o++) readback(1, 16'hD500 + 16'(o), "R9");
    readback(0, 16'hFF00, "R9");
    readback(0, 16'hFF02, "R9");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      bit own = ($urandom_range(0, 7) != 0);
      if (kind < 6) wr(1, 16'hD500 + 16'($urandom_range(0, 15)), d, own);
      else if (kind < 9) wr(0, 16'hFF00 + 16'($urandom_range(0, 7)), d, own);
      else wr(0, 16'($urandom), d, own);
      for (int k = 0; k < 3; k++)
        probe(pick_addr(), $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0, $urandom_range(0, 4) != 0);
      if (n % 4 == 0) readback(1, 16'hD500 + 16'($urandom_range(0, 15)), "R9");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule